// File: doc/BRIEF.md
# Branch Target Predictor with Two-Bit Confidence

This block sits in the instruction fetch stage. Each cycle the fetch unit shows it the current fetch address, and in the same cycle the block returns the address to fetch next. It keeps a direct-mapped table. Each entry holds a valid bit, an address tag, a stored jump destination and a two-bit confidence state. When the fetch address matches a valid entry whose state leans towards taken, the next fetch address is the stored destination, so a correctly predicted taken branch costs no cycle. In every other case the next fetch address is the fetch address plus four.

A second port reports each branch when it resolves: its address, whether it was taken, and its real destination. In that same cycle the block compares the outcome with what the table holds now. It flags a misprediction and gives the corrected fetch address. At the next clock edge it then trains the table. A hit moves the entry's confidence state one step towards the outcome, and a taken outcome also refreshes the stored destination. A miss that resolves taken claims the entry for that branch. A miss that resolves not taken leaves the table untouched.

Each entry's confidence is a small state machine with four states. STRONG_NT is 00 and WEAK_NT is 01; both predict not taken. WEAK_T is 10 and STRONG_T is 11; both predict taken. A taken outcome steps the state STRONG_NT→WEAK_NT→WEAK_T→STRONG_T, and STRONG_T stays at STRONG_T. A not-taken outcome steps the state the other way, and STRONG_NT stays at STRONG_NT. An entry that is claimed starts in WEAK_T.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid. Every lookup then reports no hit and not taken, and gives the fetch address plus 4 as the next address.
- R2: The entry is selected by fetch address bits [IDX_W+1:2], and the tag is bits [PC_W-1:IDX_W+2]. A lookup hits only on a valid entry whose tag matches, so two addresses that differ only in the tag bits do not hit each other's entry. A taken miss replaces the entry at that index.
- R3: When a lookup hits and the entry's state is 10 or 11, pred_taken is 1 and the next address is the stored destination. When it hits with state 00 or 01, pred_hit is 1, pred_taken is 0 and the next address is the fetch address plus 4.
- R4: A resolved taken branch that misses is allocated with its tag, its destination and state 10. A lookup of that address from the next cycle on predicts taken to that destination.
- R5: A resolved not-taken branch that misses allocates nothing, and later lookups of it still miss.
- R6: The state saturates: a taken outcome in state 11 leaves it at 11, and a not-taken outcome in state 00 leaves it at 00.
- R7: An entry in state 11 needs two successive not-taken outcomes before its prediction becomes not taken, and an entry in state 00 needs two successive taken outcomes before its prediction becomes taken.
- R8: A taken outcome that hits overwrites the stored destination, and the next lookup predicts the new destination.
- R9: In the cycle of a valid resolution, res_mispredict is 1 when the table's current prediction for res_pc differs from the outcome in direction, or when both say taken and the stored destination differs from res_target. res_redirect_pc is res_target if the branch was taken, otherwise res_pc plus 4. res_mispredict is 0 whenever res_valid is 0.
- R10: When a lookup and a resolution touch the same entry in the same cycle, the lookup returns the entry's old contents. The new contents are visible from the next cycle.
- R11: A loop branch that is taken three times and then not taken, with this pattern repeated, is mispredicted exactly once per pass once its entry exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_hit | output | 1 | fetch_pc matches a valid entry |
| pred_taken | output | 1 | Hit, and the entry predicts taken |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Resolved direction |
| res_target | input | PC_W | Resolved destination when taken |
| res_mispredict | output | 1 | The current table prediction disagrees with the outcome |
| res_redirect_pc | output | PC_W | Correct fetch address after the branch |

## Verification
A corrupt confidence state shows at the ports no later than the next lookup of that branch. It appears as a wrong pred_taken, and as a wrong res_mispredict when the branch next resolves. Saturation and hysteresis faults take one or two extra outcomes to become visible, so the stimulus drives runs of the same outcome through both ends of the counter. A wrong tag or index split shows as a false hit on an aliasing address in the same cycle. A faulty write path shows as a stale destination in the cycle after a resolution.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

    localparam ctr_state_e CTR_ALLOC = CTR_WEAK_T;

endpackage

// File: rtl/btb_ctr_fsm.sv
module btb_ctr_fsm
    import btb_pkg::*;
(
    input  ctr_state_e cur_state,
    input  logic       outcome_taken,
    output ctr_state_e nxt_state,
    output logic       predict_taken
);

    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            CTR_STRONG_NT: nxt_state = outcome_taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt_state = outcome_taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt_state = outcome_taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt_state = outcome_taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt_state = CTR_STRONG_NT;
        endcase
    end

    always_comb begin
        predict_taken = 1'b0;
        unique case (cur_state)
            CTR_STRONG_NT, CTR_WEAK_NT: predict_taken = 1'b0;
            CTR_WEAK_T, CTR_STRONG_T:   predict_taken = 1'b1;
            default:                    predict_taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int ENTRIES = 1 << IDX_W,
    localparam int TAG_W   = PC_W - IDX_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target,
    input  ctr_state_e       wr_ctr,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_valid,
    output logic [TAG_W-1:0] ra_tag,
    output logic [PC_W-1:0]  ra_target,
    output ctr_state_e       ra_ctr,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_valid,
    output logic [TAG_W-1:0] rb_tag,
    output logic [PC_W-1:0]  rb_target,
    output ctr_state_e       rb_ctr
);

    logic             valid_a  [ENTRIES];
    logic [TAG_W-1:0] tag_a    [ENTRIES];
    logic [PC_W-1:0]  target_a [ENTRIES];
    ctr_state_e       ctr_a    [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic             valid_q;
        logic [TAG_W-1:0] tag_q;
        logic [PC_W-1:0]  target_q;
        ctr_state_e       ctr_q;
        logic             sel;

        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q  <= 1'b0;
                tag_q    <= '0;
                target_q <= '0;
                ctr_q    <= CTR_STRONG_NT;
            end else if (sel) begin
                valid_q  <= 1'b1;
                tag_q    <= wr_tag;
                target_q <= wr_target;
                ctr_q    <= wr_ctr;
            end
        end

        assign valid_a[e]  = valid_q;
        assign tag_a[e]    = tag_q;
        assign target_a[e] = target_q;
        assign ctr_a[e]    = ctr_q;
    end

    // Reads see the registered contents, so a write lands after the edge
    assign ra_valid  = valid_a[ra_idx];
    assign ra_tag    = tag_a[ra_idx];
    assign ra_target = target_a[ra_idx];
    assign ra_ctr    = ctr_a[ra_idx];

    assign rb_valid  = valid_a[rb_idx];
    assign rb_tag    = tag_a[rb_idx];
    assign rb_target = target_a[rb_idx];
    assign rb_ctr    = ctr_a[rb_idx];

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W = PC_W - IDX_W - 2
) (
    input  logic [PC_W-1:0]  fetch_pc,
    output logic [IDX_W-1:0] ra_idx,
    input  logic             ra_valid,
    input  logic [TAG_W-1:0] ra_tag,
    input  logic [PC_W-1:0]  ra_target,
    input  ctr_state_e       ra_ctr,
    output logic             hit,
    output logic             taken,
    output logic [PC_W-1:0]  next_pc
);

    logic       ctr_says_taken;
    ctr_state_e unused_nxt;

    assign ra_idx = fetch_pc[IDX_W+1:2];

    btb_ctr_fsm u_dir (
        .cur_state     (ra_ctr),
        .outcome_taken (1'b0),
        .nxt_state     (unused_nxt),
        .predict_taken (ctr_says_taken)
    );

    always_comb begin
        hit     = ra_valid && (ra_tag == fetch_pc[PC_W-1:IDX_W+2]);
        taken   = hit && ctr_says_taken;
        next_pc = taken ? ra_target : fetch_pc + PC_W'(4);
    end

endmodule

// File: rtl/btb_update.sv
module btb_update
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W = PC_W - IDX_W - 2
) (
    input  logic             res_valid,
    input  logic [PC_W-1:0]  res_pc,
    input  logic             res_taken,
    input  logic [PC_W-1:0]  res_target,
    output logic [IDX_W-1:0] rb_idx,
    input  logic             rb_valid,
    input  logic [TAG_W-1:0] rb_tag,
    input  logic [PC_W-1:0]  rb_target,
    input  ctr_state_e       rb_ctr,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [TAG_W-1:0] wr_tag,
    output logic [PC_W-1:0]  wr_target,
    output ctr_state_e       wr_ctr,
    output logic             mispredict,
    output logic [PC_W-1:0]  redirect_pc
);

    logic       hit;
    logic       was_taken;
    logic       ctr_says_taken;
    ctr_state_e trained;

    assign rb_idx = res_pc[IDX_W+1:2];

    btb_ctr_fsm u_train (
        .cur_state     (rb_ctr),
        .outcome_taken (res_taken),
        .nxt_state     (trained),
        .predict_taken (ctr_says_taken)
    );

    always_comb begin
        hit         = rb_valid && (rb_tag == res_pc[PC_W-1:IDX_W+2]);
        was_taken   = hit && ctr_says_taken;
        mispredict  = res_valid &&
                      ((was_taken != res_taken) ||
                       (res_taken && (rb_target != res_target)));
        redirect_pc = res_taken ? res_target : res_pc + PC_W'(4);

        wr_en     = res_valid && (hit || res_taken);
        wr_idx    = rb_idx;
        wr_tag    = res_pc[PC_W-1:IDX_W+2];
        wr_target = res_taken ? res_target : rb_target;
        wr_ctr    = hit ? trained : CTR_ALLOC;
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target,
    output logic            res_mispredict,
    output logic [PC_W-1:0] res_redirect_pc
);

    localparam int TAG_W = PC_W - IDX_W - 2;

    logic [IDX_W-1:0] ra_idx, rb_idx, wr_idx;
    logic             ra_valid, rb_valid, wr_en;
    logic [TAG_W-1:0] ra_tag, rb_tag, wr_tag;
    logic [PC_W-1:0]  ra_target, rb_target, wr_target;
    ctr_state_e       ra_ctr, rb_ctr, wr_ctr;

    btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_target (wr_target),
        .wr_ctr    (wr_ctr),
        .ra_idx    (ra_idx),
        .ra_valid  (ra_valid),
        .ra_tag    (ra_tag),
        .ra_target (ra_target),
        .ra_ctr    (ra_ctr),
        .rb_idx    (rb_idx),
        .rb_valid  (rb_valid),
        .rb_tag    (rb_tag),
        .rb_target (rb_target),
        .rb_ctr    (rb_ctr)
    );

    btb_lookup #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lookup (
        .fetch_pc  (fetch_pc),
        .ra_idx    (ra_idx),
        .ra_valid  (ra_valid),
        .ra_tag    (ra_tag),
        .ra_target (ra_target),
        .ra_ctr    (ra_ctr),
        .hit       (pred_hit),
        .taken     (pred_taken),
        .next_pc   (pred_next_pc)
    );

    btb_update #(.PC_W(PC_W), .IDX_W(IDX_W)) u_update (
        .res_valid   (res_valid),
        .res_pc      (res_pc),
        .res_taken   (res_taken),
        .res_target  (res_target),
        .rb_idx      (rb_idx),
        .rb_valid    (rb_valid),
        .rb_tag      (rb_tag),
        .rb_target   (rb_target),
        .rb_ctr      (rb_ctr),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_tag      (wr_tag),
        .wr_target   (wr_target),
        .wr_ctr      (wr_ctr),
        .mispredict  (res_mispredict),
        .redirect_pc (res_redirect_pc)
    );

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_hit,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_next_pc,
    input logic            res_valid,
    input logic [PC_W-1:0] res_pc,
    input logic            res_taken,
    input logic [PC_W-1:0] res_target,
    input logic            res_mispredict,
    input logic [PC_W-1:0] res_redirect_pc
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R3: a taken prediction only comes from a hit
    a_r3_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);

    // R3: without a taken prediction, fetch continues sequentially
    a_r3_sequential_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_next_pc == fetch_pc + PC_W'(4));

    // R4: a branch resolved taken is present in the table one cycle later
    a_r4_taken_allocates: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(res_valid && res_taken) && fetch_pc == $past(res_pc)) |-> pred_hit);

    // R9: no resolution, no misprediction report
    a_r9_quiet_port: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_mispredict);

    // R9: a not-taken branch redirects to the sequential address
    a_r9_redirect_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |-> res_redirect_pc == res_pc + PC_W'(4));

    // R10: without a resolution the table cannot change its answer
    a_r10_stable_without_update: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(!res_valid) && $stable(fetch_pc))
            |-> ($stable(pred_next_pc) && $stable(pred_hit) && $stable(pred_taken)));

endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_pc        (fetch_pc),
    .pred_hit        (pred_hit),
    .pred_taken      (pred_taken),
    .pred_next_pc    (pred_next_pc),
    .res_valid       (res_valid),
    .res_pc          (res_pc),
    .res_taken       (res_taken),
    .res_target      (res_target),
    .res_mispredict  (res_mispredict),
    .res_redirect_pc (res_redirect_pc)
);

// File: tb/sim_btb_predictor.sv
`timescale 1ns/1ps
module sim_btb_predictor;

    localparam int PC_W = 32;
    localparam int VW   = 1 + 32 + 1 + 32 + 32 + 1 + 1 + 32 + 1 + 32;
    localparam int NV   = 21;

    // {res_valid, res_pc, res_taken, res_target, fetch_pc,
    //  exp_hit, exp_taken, exp_next_pc, exp_mispredict, exp_redirect}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b0, 1'b0, 32'h104, 1'b0, 32'h0},
        {1'b1, 32'h100, 1'b0, 32'h0,   32'h100, 1'b0, 1'b0, 32'h104, 1'b0, 32'h104},
        {1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b0, 1'b0, 32'h104, 1'b0, 32'h0},
        {1'b1, 32'h100, 1'b1, 32'h200, 32'h100, 1'b0, 1'b0, 32'h104, 1'b1, 32'h200},
        {1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 32'h0},
        {1'b0, 32'h0,   1'b0, 32'h0,   32'h140, 1'b0, 1'b0, 32'h144, 1'b0, 32'h0},
        {1'b1, 32'h100, 1'b1, 32'h200, 32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 32'h200},
        {1'b1, 32'h100, 1'b1, 32'h200, 32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 32'h200},
        {1'b1, 32'h100, 1'b0, 32'h0,   32'h100, 1'b1, 1'b1, 32'h200, 1'b1, 32'h104},
        {1'b1, 32'h100, 1'b0, 32'h0,   32'h100, 1'b1, 1'b1, 32'h200, 1'b1, 32'h104},
        {1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b1, 1'b0, 32'h104, 1'b0, 32'h0},
        {1'b1, 32'h100, 1'b0, 32'h0,   32'h100, 1'b1, 1'b0, 32'h104, 1'b0, 32'h104},
        {1'b1, 32'h100, 1'b0, 32'h0,   32'h100, 1'b1, 1'b0, 32'h104, 1'b0, 32'h104},
        {1'b1, 32'h100, 1'b1, 32'h200, 32'h100, 1'b1, 1'b0, 32'h104, 1'b1, 32'h200},
        {1'b1, 32'h100, 1'b1, 32'h200, 32'h100, 1'b1, 1'b0, 32'h104, 1'b1, 32'h200},
        {1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 32'h0},
        {1'b1, 32'h100, 1'b1, 32'h300, 32'h104, 1'b0, 1'b0, 32'h108, 1'b1, 32'h300},
        {1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b1, 1'b1, 32'h300, 1'b0, 32'h0},
        {1'b1, 32'h140, 1'b1, 32'h500, 32'h100, 1'b1, 1'b1, 32'h300, 1'b1, 32'h500},
        {1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b0, 1'b0, 32'h104, 1'b0, 32'h0},
        {1'b0, 32'h0,   1'b0, 32'h0,   32'h140, 1'b1, 1'b1, 32'h500, 1'b0, 32'h0}
    };

    // Requirement exercised by each vector row
    localparam string VREQ [NV] = '{
        "R1", "R5", "R5", "R10", "R4", "R2", "R3", "R6", "R7", "R7", "R3",
        "R7", "R6", "R6", "R7", "R6", "R9", "R8", "R10", "R2", "R2"
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            pred_hit, pred_taken, res_mispredict;
    logic [PC_W-1:0] pred_next_pc, res_redirect_pc;
    logic            res_valid = 1'b0;
    logic [PC_W-1:0] res_pc = '0;
    logic            res_taken = 1'b0;
    logic [PC_W-1:0] res_target = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    btb_predictor u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .fetch_pc        (fetch_pc),
        .pred_hit        (pred_hit),
        .pred_taken      (pred_taken),
        .pred_next_pc    (pred_next_pc),
        .res_valid       (res_valid),
        .res_pc          (res_pc),
        .res_taken       (res_taken),
        .res_target      (res_target),
        .res_mispredict  (res_mispredict),
        .res_redirect_pc (res_redirect_pc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] p, input logic t,
                         input logic [31:0] g, input logic [31:0] f);
        @(negedge clk);
        res_valid  = v;
        res_pc     = p;
        res_taken  = t;
        res_target = g;
        fetch_pc   = f;
        #5;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            drive(v[164], v[163:132], v[131], v[130:99], v[98:67]);
            chk(VREQ[i], "pred_hit",     32'(pred_hit),     32'(v[66]));
            chk(VREQ[i], "pred_taken",   32'(pred_taken),   32'(v[65]));
            chk(VREQ[i], "pred_next_pc", pred_next_pc,      v[64:33]);
            chk(VREQ[i], "mispredict",   32'(res_mispredict), 32'(v[32]));
            if (v[164]) chk(VREQ[i], "redirect", res_redirect_pc, v[31:0]);
        end

        // R1: reset empties the table (0x140 was live before)
        @(negedge clk);
        res_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 32'h0, 1'b0, 32'h0, 32'h140);
        chk("R1", "hit after reset",  32'(pred_hit),   32'd0);
        chk("R1", "taken after reset", 32'(pred_taken), 32'd0);
        chk("R1", "next after reset", pred_next_pc,    32'h144);

        // R11: loop branch at 0x104, taken 3 times then falls through, 4 passes
        for (int pass = 0; pass < 4; pass++) begin
            int misses;
            misses = 0;
            for (int k = 0; k < 4; k++) begin
                drive(1'b1, 32'h104, (k < 3), 32'h0F0, 32'h104);
                if (res_mispredict) misses++;
            end
            chk("R11", $sformatf("mispredicts in pass %0d", pass),
                32'(misses), (pass == 0) ? 32'd2 : 32'd1);
        end
        drive(1'b0, 32'h0, 1'b0, 32'h0, 32'h104);
        chk("R11", "loop entry after exit", 32'(pred_taken), 32'd1);

        summary();
    end

endmodule